// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins from outside the chip and records each event in a pending bit. Every pin has its own sense mode: falling edge, rising edge, low level, high level or both edges. A pin raises its own request line only when three conditions hold together. Its event must be pending, it must not be masked, and its 4-bit priority field must be non-zero. A single combined request output ORs all the per-pin request lines.

Software controls the block through a plain valid/write/address/data port with five registers. Two are read-write: the sense modes and the priority levels. One is readable and cleared by writing zeros: the pending events. Two are write-only: the mask-set and mask-clear registers. Fields are packed from the most significant end, so pin 0 always owns the top field or bit. Reads return data in the same cycle. Writes take effect at the next clock edge.

Top module: `irqpin_ctrl`

## Requirements
- R1: After reset every pin is masked, all priority fields are 0, all pending bits are 0 and all sense fields are 0. The sense, priority and pending registers read back as 0, and no request output is active.
- R2: Each pin passes through two synchroniser flops and then an edge register. A pin change set up before clock edge k shows in the pending register after edge k+2 and not after edge k+1.
- R3: The sense register is at address 0. Pin n's field (width SENSE_W, 2 or 4) sits at bits [31-n*SENSE_W -: SENSE_W]. The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 both edges. Any other code detects nothing.
- R4: In a level mode the pending bit is set again on every cycle the active level is present, so a clear written while the level persists leaves the bit set.
- R5: The pending register is at address 2. Pin n is at bit SRC_W-1-n (SRC_W is 8 by default). All other bits read 0.
- R6: A write to address 2 clears each pending bit written as 0 and keeps each bit written as 1. An event detected in the same cycle as a clear wins.
- R7: Address 3 is the mask-set register. Writing 1 at pin n's bit (SRC_W-1-n) masks the pin, and bits written as 0 change nothing.
- R8: Address 4 is the mask-clear register. Writing 1 at pin n's bit (SRC_W-1-n) unmasks the pin, and bits written as 0 change nothing.
- R9: The priority register is at address 1, with pin n's 4-bit field at bits [31-4n -: 4]. A field of 0 blocks the pin's request, and any non-zero value lets it through.
- R10: irq_pin[n] is high exactly when pin n is pending, unmasked and has a non-zero priority. irq_any is the OR of all irq_pin bits.
- R11: Reads of addresses 3 to 7 return 0. Writes to addresses 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Asynchronous interrupt pins, bit n is pin n |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| irq_pin | output | NUM_PINS | Per-pin request, bit n is pin n |
| irq_any | output | 1 | OR of all per-pin requests |

## Verification
A corrupted pending, mask or priority bit shows on irq_pin in the cycle after the clock edge that stores it, and on the pending read in that same cycle. An error in the synchroniser or the edge register shows as an event that arrives one cycle early or late, or never arrives. This is caught because one pin change is timed against the exact edge. A bit-order or field-offset error moves the effect to the wrong pin, so both the pending read and the request lines disagree with an independent model within three cycles of the stimulus.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;
    localparam int PRIO_W = 4;

    // sense codes
    localparam int SNS_FALL = 0;
    localparam int SNS_RISE = 1;
    localparam int SNS_LOW  = 2;
    localparam int SNS_HIGH = 3;
    localparam int SNS_BOTH = 4;

    typedef enum logic [2:0] {
        ADR_SENSE = 3'd0,
        ADR_PRIO  = 3'd1,
        ADR_SRC   = 3'd2,
        ADR_MSET  = 3'd3,
        ADR_MCLR  = 3'd4
    } adr_e;
endpackage

// File: rtl/irqpin_sync.sv
module irqpin_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] cur,
    output logic [NUM_PINS-1:0] prv
);
    logic [NUM_PINS-1:0] s1_d, s1_q, s2_d, s2_q, pv_d, pv_q;

    always_comb begin
        s1_d = pin_in;
        s2_d = s1_q;
        pv_d = s2_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            pv_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            pv_q <= pv_d;
        end
    end

    assign cur = s2_q;
    assign prv = pv_q;
endmodule

// File: rtl/irqpin_detect.sv
module irqpin_detect
    import irqpin_pkg::*;
#(
    parameter int SENSE_W = 4
) (
    input  logic [SENSE_W-1:0] mode,
    input  logic               cur,
    input  logic               prv,
    output logic               event_o
);
    always_comb begin
        case (int'(mode))
            SNS_FALL: event_o = prv & ~cur;
            SNS_RISE: event_o = ~prv & cur;
            SNS_LOW:  event_o = ~cur;
            SNS_HIGH: event_o = cur;
            SNS_BOTH: event_o = prv ^ cur;
            default:  event_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqpin_gate.sv
module irqpin_gate
    import irqpin_pkg::*;
(
    input  logic              pend,
    input  logic              masked,
    input  logic [PRIO_W-1:0] level,
    output logic              req
);
    assign req = pend & ~masked & (|level);
endmodule

// File: rtl/irqpin_ctrl.sv
module irqpin_ctrl
    import irqpin_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_valid,
    input  logic                reg_write,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PINS-1:0] irq_pin,
    output logic                irq_any
);
    localparam int TOP = 31;

    typedef struct packed {
        logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
        logic [NUM_PINS-1:0][PRIO_W-1:0]  prio;
        logic [NUM_PINS-1:0]              pend;
        logic [NUM_PINS-1:0]              mask;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_PINS-1:0] cur, prv, ev;
    logic [31:0] rd;
    logic wr;

    irqpin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prv(prv)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        irqpin_detect #(.SENSE_W(SENSE_W)) u_det (
            .mode(st_q.sense[n]), .cur(cur[n]), .prv(prv[n]), .event_o(ev[n])
        );
        irqpin_gate u_gate (
            .pend(st_q.pend[n]), .masked(st_q.mask[n]),
            .level(st_q.prio[n]), .req(irq_pin[n])
        );
    end

    assign wr = reg_valid & reg_write;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (reg_addr)
                ADR_SENSE: for (int n = 0; n < NUM_PINS; n++)
                               st_d.sense[n] = reg_wdata[TOP-n*SENSE_W -: SENSE_W];
                ADR_PRIO:  for (int n = 0; n < NUM_PINS; n++)
                               st_d.prio[n] = reg_wdata[TOP-n*PRIO_W -: PRIO_W];
                ADR_SRC:   for (int n = 0; n < NUM_PINS; n++)
                               if (!reg_wdata[SRC_W-1-n]) st_d.pend[n] = 1'b0;
                ADR_MSET:  for (int n = 0; n < NUM_PINS; n++)
                               if (reg_wdata[SRC_W-1-n]) st_d.mask[n] = 1'b1;
                ADR_MCLR:  for (int n = 0; n < NUM_PINS; n++)
                               if (reg_wdata[SRC_W-1-n]) st_d.mask[n] = 1'b0;
                default: ;
            endcase
        end
        st_d.pend = st_d.pend | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd = '0;
        case (reg_addr)
            ADR_SENSE: for (int n = 0; n < NUM_PINS; n++)
                           rd[TOP-n*SENSE_W -: SENSE_W] = st_q.sense[n];
            ADR_PRIO:  for (int n = 0; n < NUM_PINS; n++)
                           rd[TOP-n*PRIO_W -: PRIO_W] = st_q.prio[n];
            ADR_SRC:   for (int n = 0; n < NUM_PINS; n++)
                           rd[SRC_W-1-n] = st_q.pend[n];
            default: ;
        endcase
        reg_rdata = (reg_valid && !reg_write) ? rd : '0;
    end

    assign irq_any = |irq_pin;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
        assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr && reg_addr == ADR_MSET && reg_wdata[SRC_W-1-n] |=> !irq_pin[n]);
        assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
            wr && reg_addr == ADR_MCLR && reg_wdata[SRC_W-1-n] |=> !st_q.mask[n]);
        assert_prio_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr && reg_addr == ADR_PRIO && reg_wdata[TOP-n*PRIO_W -: PRIO_W] == '0
            |=> !irq_pin[n]);
        assert_src_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wr && reg_addr == ADR_SRC && !reg_wdata[SRC_W-1-n] && !ev[n]
            |=> !st_q.pend[n]);
        assert_pend_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.pend[n]) |-> $past(ev[n]));
        assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(st_q.sense[n]) == SNS_LOW && !cur[n] |=> st_q.pend[n]);
    end
endmodule

// File: tb/tb_irqpin_ctrl.sv
module tb_irqpin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        reg_valid = 1'b1, reg_write = 1'b0;
    logic [2:0]  reg_addr = 3'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_pin;
    logic        irq_any;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    irqpin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_valid(reg_valid),
        .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pin(irq_pin), .irq_any(irq_any)
    );

    // reference model built from the requirements
    logic [7:0]  m_s1, m_s2, m_pv, m_pend, m_mask;
    logic [31:0] m_sense, m_prio;

    function automatic logic evf(logic [3:0] mode, logic c, logic p);
        case (mode)
            4'd0: return p & ~c;
            4'd1: return ~p & c;
            4'd2: return ~c;
            4'd3: return c;
            4'd4: return p ^ c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] src_of(logic [7:0] v);
        logic [31:0] r = '0;
        for (int n = 0; n < 8; n++) r[7-n] = v[n];
        return r;
    endfunction

    function automatic logic [7:0] irq_of();
        logic [7:0] r;
        for (int n = 0; n < 8; n++)
            r[n] = m_pend[n] & ~m_mask[n] & (m_prio[31-4*n -: 4] != 4'd0);
        return r;
    endfunction

    always @(posedge clk) begin
        logic [7:0] nxt;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_pend <= '0;
            m_mask <= '1; m_sense <= '0; m_prio <= '0;
        end else begin
            m_s1 <= pins; m_s2 <= m_s1; m_pv <= m_s2;
            nxt = m_pend;
            if (reg_valid && reg_write) begin
                case (reg_addr)
                    3'd0: m_sense <= reg_wdata;
                    3'd1: m_prio <= reg_wdata;
                    3'd2: for (int n = 0; n < 8; n++) if (!reg_wdata[7-n]) nxt[n] = 1'b0;
                    3'd3: for (int n = 0; n < 8; n++) if (reg_wdata[7-n]) m_mask[n] <= 1'b1;
                    3'd4: for (int n = 0; n < 8; n++) if (reg_wdata[7-n]) m_mask[n] <= 1'b0;
                    default: ;
                endcase
            end
            for (int n = 0; n < 8; n++)
                nxt[n] = nxt[n] | evf(m_sense[31-4*n -: 4], m_s2[n], m_pv[n]);
            m_pend <= nxt;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_write = 1'b0; reg_addr = 3'd2;
    endtask

    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        reg_write = 1'b0; reg_addr = a;
        #0.5 d = reg_rdata;
        reg_addr = 3'd2;
        #0.5;
    endtask

    task automatic cmp_model(string tag);
        #0.1;
        chk({tag, " pending"}, reg_rdata, src_of(m_pend));
        chk({tag, " irq_pin"}, {24'd0, irq_pin}, {24'd0, irq_of()});
        chk({tag, " irq_any"}, {31'd0, irq_any}, {31'd0, |irq_of()});
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_reg(3'd0, v); chk("R1 sense", v, 32'd0);
        rd_reg(3'd1, v); chk("R1 prio", v, 32'd0);
        rd_reg(3'd2, v); chk("R1 pending", v, 32'd0);
        chk("R1 irq_any", {31'd0, irq_any}, 32'd0);
        // R9 priority readback, R8 unmask
        wr_reg(3'd1, 32'hFFFF_FFFF);
        rd_reg(3'd1, v); chk("R9 prio readback", v, 32'hFFFF_FFFF);
        wr_reg(3'd4, 32'h0000_00FF);
        chk("R8 no pending no irq", {31'd0, irq_any}, 32'd0);
        // R3 modes: pin0 fall, 1 rise, 2 low, 3 high, 4 both, 5 none, 6 rise, 7 fall
        wr_reg(3'd0, 32'h0123_4510);
        rd_reg(3'd0, v); chk("R3 sense readback", v, 32'h0123_4510);
        repeat (4) @(negedge clk);
        rd_reg(3'd2, v); chk("R3 R5 low level pin2 at bit5", v, 32'h0000_0020);
        chk("R10 irq_pin pin2", {24'd0, irq_pin}, 32'h0000_0004);
        // R7 mask-set
        wr_reg(3'd3, 32'h0); chk("R7 zero bits no effect", {24'd0, irq_pin}, 32'h4);
        wr_reg(3'd3, 32'h20); chk("R7 mask pin2", {24'd0, irq_pin}, 32'h0);
        rd_reg(3'd2, v); chk("R7 pending kept", v, 32'h20);
        // R8 mask-clear
        wr_reg(3'd4, 32'h0); chk("R8 zero bits no effect", {24'd0, irq_pin}, 32'h0);
        wr_reg(3'd4, 32'h20); chk("R8 unmask pin2", {24'd0, irq_pin}, 32'h4);
        // R4 level persists over a clear
        wr_reg(3'd2, 32'h0);
        rd_reg(3'd2, v); chk("R4 level re-asserts", v & 32'h20, 32'h20);
        // R2 timing on pin0 falling edge
        pins[0] = 1'b1;
        repeat (4) @(negedge clk);
        cmp_model("R3 rising in fall mode");
        pins[0] = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_reg(3'd2, v); chk("R2 not yet after k+1", v & 32'h80, 32'h0);
        @(negedge clk);
        rd_reg(3'd2, v); chk("R2 pending after k+2", v & 32'h80, 32'h80);
        // R6 write-one keeps, write-zero clears
        wr_reg(3'd2, 32'hFF);
        rd_reg(3'd2, v); chk("R6 ones keep", v & 32'h80, 32'h80);
        wr_reg(3'd2, 32'h7F);
        rd_reg(3'd2, v); chk("R6 zero clears pin0", v & 32'h80, 32'h0);
        // R9 zero field blocks, non-zero passes
        wr_reg(3'd1, 32'hFF0F_FFFF);
        chk("R9 zero prio blocks pin2", {31'd0, irq_pin[2]}, 32'd0);
        wr_reg(3'd1, 32'hFF1F_FFFF);
        chk("R9 prio 1 passes pin2", {31'd0, irq_pin[2]}, 32'd1);
        // R3 both edges on pin4, none on pin5
        pins[4] = 1'b1; pins[5] = 1'b1;
        repeat (4) @(negedge clk);
        rd_reg(3'd2, v); chk("R3 both edges rise", v & 32'h0C, 32'h08);
        wr_reg(3'd2, 32'hF7);
        pins[4] = 1'b0; pins[5] = 1'b0;
        repeat (4) @(negedge clk);
        rd_reg(3'd2, v); chk("R3 both edges fall, code 5 none", v & 32'h0C, 32'h08);
        cmp_model("R3 model");
        // R11 unused addresses
        rd_reg(3'd3, v); chk("R11 read mask-set", v, 32'h0);
        rd_reg(3'd6, v); chk("R11 read addr6", v, 32'h0);
        wr_reg(3'd6, 32'hFFFF_FFFF);
        rd_reg(3'd0, v); chk("R11 write addr6 ignored", v, 32'h0123_4510);
        cmp_model("R11 model");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic did_wr;
            did_wr = 1'b0;
            for (int n = 0; n < 8; n++) if ($urandom_range(7) == 0) pins[n] = ~pins[n];
            if ($urandom_range(15) == 0) begin
                wr_reg(3'($urandom_range(4)), $urandom());
                did_wr = 1'b1;
            end else begin
                @(negedge clk);
            end
            if (!did_wr || reg_addr == 3'd2) cmp_model("R5 R10 random");
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule